// File: doc/BRIEF.md
# Indexed Per-Pin GPIO Controller

This block is a memory-mapped general-purpose I/O controller in which every pin is configured through a 32-bit control word of its own. That word holds the pin's output value, its direction, its interrupt enable and trigger type, and an input gate. It also shows a pending-interrupt flag that software clears by writing one, and the pin's synchronised input level. Because each pin has its own word, software can configure or acknowledge one pin without a read-modify-write of a shared register. An acknowledge therefore touches exactly one pin.

Pins are arranged as groups of eight. The default build has 27 groups, and four slots of the eighth group (group index 7, pins 60 to 63) are left unpopulated. Inputs pass through a two-stage synchroniser before edge or level detection. A pending counter tracks how many pins currently have their flag set, and the single interrupt line is high while that counter is nonzero. The register window is 4 KB. Control words start at byte offset 0x100, and pin n sits at 0x100 + 4*n.

Top module: `gpio_idx_ctrl`

## Requirements
- R1: The control word of pin n is at byte address 0x100 + 4*n. Its writable fields read back as follows: bit 0 output value, bit 1 direction (1 = drive), bit 2 interrupt enable, bits 4:3 trigger type, bit 5 input gate. Bits 6 to 11 and 14 to 31 read as zero.
- R2: gpio_out[n] follows bit 0 and gpio_oe[n] follows bit 1 of pin n's word from the clock edge that accepts the write, and both hold their value until the next write to that pin.
- R3: After reset every control word reads zero, every gpio_oe bit is low, irq_count is zero and irq_o is low.
- R4: Bit 13 shows gpio_in[n] after two synchroniser stages and one capture register. A change on the input reads back after the third rising edge and not after the second. Writes to bit 13 have no effect.
- R5: With the interrupt enabled, trigger type 00 sets the flag (bit 12) on a falling input, type 01 on a rising input and type 10 on either edge. An edge of the other polarity does not set it.
- R6: Trigger type 11 sets the flag while the synchronised input is high. An acknowledge written while the input is still high leaves the flag set and the count unchanged, because a set and a clear in the same cycle resolve as a set.
- R7: With bit 2 clear, no input activity sets the flag.
- R8: With bit 5 set, bit 13 keeps its last value and input changes raise no interrupt.
- R9: Writing 1 to bit 12 clears only the addressed pin's flag. Writing 0 to bit 12 leaves it unchanged. Flags of other pins are never cleared by the write.
- R10: irq_count rises by one for each flag that goes from 0 to 1 (several in one cycle add up) and falls by one for each flag that goes from 1 to 0. irq_o is high exactly while irq_count is nonzero.
- R11: Absent pins (group 7, pins 60 to 63) read as zero, ignore writes and never drive gpio_oe.
- R12: Addresses below 0x100, at or above 0x100 + 4*216, or not word aligned read as zero, and writes to them change no pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| gpio_in | input | 216 | Pad input levels |
| gpio_out | output | 216 | Pad output values |
| gpio_oe | output | 216 | Pad output enables |
| irq_o | output | 1 | Aggregated interrupt |
| irq_count | output | 8 | Number of pins with a pending flag |

## Verification
The most important corner case is an acknowledge issued while two pins are pending. A design that cleared the whole set would drop the count to zero and lower irq_o, when it should leave one pin pending with a count of one. A write with a zero in the flag bit is also exercised, because a design that deposits the written bit instead of treating it as write-one-to-clear would lose the flag. A level-triggered pin is acknowledged while its input is still high, so a design where the clear beats the set would briefly report no interrupt. Two pins are raised in the same cycle to catch a counter that adds only one. Reads and writes at absent pins and at unmapped or misaligned offsets would otherwise alias onto real pins.

// File: rtl/gpio_idx_pkg.sv
package gpio_idx_pkg;

   localparam int DOUT_BIT = 0;
   localparam int DIR_BIT  = 1;
   localparam int IEN_BIT  = 2;
   localparam int TRIG_LSB = 3;
   localparam int GATE_BIT = 5;
   localparam int CFG_W    = 6;
   localparam int FLAG_BIT = 12;
   localparam int LVL_BIT  = 13;

   typedef enum logic [1:0] {
      TRIG_FALL  = 2'b00,
      TRIG_RISE  = 2'b01,
      TRIG_BOTH  = 2'b10,
      TRIG_LEVEL = 2'b11
   } trig_e;

   // packed order places each field at its bit position in the control word
   typedef struct packed {
      logic  in_gate;
      trig_e trig;
      logic  irq_en;
      logic  drive;
      logic  dout;
   } pin_cfg_t;

   function automatic bit pin_present(int idx, int per_grp, int hole_grp, int hole_first);
      return !((idx / per_grp) == hole_grp && (idx % per_grp) >= hole_first);
   endfunction

endpackage

// File: rtl/gpio_idx_sync.sv
module gpio_idx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_idx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_idx_pin.sv
module gpio_idx_pin
   import gpio_idx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_sync,
   input  logic        wr_en,
   input  pin_cfg_t    wcfg,
   input  logic        wack,
   output logic [31:0] rd_word,
   output logic        pad_out,
   output logic        pad_oe,
   output logic        set_pulse,
   output logic        clr_pulse
);
   pin_cfg_t cfg_q;
   logic     flag_q;
   logic     lvl_q;
   logic     rise, fall, hit, evt, ack;

   always_comb begin
      rise = !cfg_q.in_gate &&  in_sync && !lvl_q;
      fall = !cfg_q.in_gate && !in_sync &&  lvl_q;
      unique case (cfg_q.trig)
         TRIG_FALL:  hit = fall;
         TRIG_RISE:  hit = rise;
         TRIG_BOTH:  hit = rise | fall;
         default:    hit = !cfg_q.in_gate && in_sync;
      endcase
      evt       = cfg_q.irq_en && hit;
      ack       = wr_en && wack;
      set_pulse = evt && !flag_q;
      clr_pulse = ack && flag_q && !evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         flag_q <= 1'b0;
         lvl_q  <= 1'b0;
      end else begin
         if (wr_en)           cfg_q  <= wcfg;
         if (!cfg_q.in_gate)  lvl_q  <= in_sync;
         if (evt)             flag_q <= 1'b1;
         else if (ack)        flag_q <= 1'b0;
      end
   end

   always_comb begin
      rd_word                  = '0;
      rd_word[CFG_W-1:0]       = cfg_q;
      rd_word[FLAG_BIT]        = flag_q;
      rd_word[LVL_BIT]         = lvl_q;
   end

   assign pad_out = cfg_q.dout;
   assign pad_oe  = cfg_q.drive;
endmodule

// File: rtl/gpio_idx_pend.sv
module gpio_idx_pend #(
   parameter int N  = 216,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  set_vec,
   input  logic [N-1:0]  clr_vec,
   output logic [CW-1:0] count
);
   logic [CW-1:0] ups, downs;

   always_comb begin
      ups   = '0;
      downs = '0;
      for (int k = 0; k < N; k++) begin
         ups   = ups   + CW'(set_vec[k]);
         downs = downs + CW'(clr_vec[k]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count + ups - downs;
   end
endmodule

// File: rtl/gpio_idx_ctrl.sv
module gpio_idx_ctrl
   import gpio_idx_pkg::*;
#(
   parameter int NUM_GROUPS     = 27,
   parameter int PINS_PER_GROUP = 8,
   parameter int HOLE_GROUP     = 7,
   parameter int HOLE_FIRST     = 4,
   parameter int WINDOW_BYTES   = 4096,
   parameter int REG_BASE       = 256,
   parameter int SYNC_STAGES    = 2,
   localparam int NUM_PINS      = NUM_GROUPS * PINS_PER_GROUP,
   localparam int ADDR_W        = $clog2(WINDOW_BYTES),
   localparam int IDX_W         = ADDR_W - 2,
   localparam int CNT_W         = $clog2(NUM_PINS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] gpio_in,
   output logic [NUM_PINS-1:0] gpio_out,
   output logic [NUM_PINS-1:0] gpio_oe,
   output logic                irq_o,
   output logic [CNT_W-1:0]    irq_count
);
   if (REG_BASE % 4 != 0) begin : g_bad_base
      $error("gpio_idx_ctrl: REG_BASE must be word aligned");
   end
   if (REG_BASE + 4 * NUM_PINS > WINDOW_BYTES) begin : g_bad_window
      $error("gpio_idx_ctrl: pin words overflow the register window");
   end
   if ((1 << ADDR_W) != WINDOW_BYTES) begin : g_bad_pow2
      $error("gpio_idx_ctrl: WINDOW_BYTES must be a power of two");
   end

   logic [ADDR_W-1:0] off;
   logic [IDX_W-1:0]  idx;
   logic              hit, wr_hit;
   logic [31:0]       rd_words [NUM_PINS];
   logic [NUM_PINS-1:0] set_vec, clr_vec;
   logic              wd_unused;

   assign off    = bus_addr - ADDR_W'(REG_BASE);
   assign idx    = off[ADDR_W-1:2];
   assign hit    = (bus_addr >= ADDR_W'(REG_BASE)) && (off[1:0] == 2'b00)
                   && ({2'b00, idx} < ADDR_W'(NUM_PINS));
   assign wr_hit = bus_sel && bus_wr && hit;
   assign wd_unused = ^{bus_wdata[31:LVL_BIT], bus_wdata[FLAG_BIT-1:CFG_W]};

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      if (pin_present(i, PINS_PER_GROUP, HOLE_GROUP, HOLE_FIRST)) begin : g_live
         logic s_in;
         gpio_idx_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst_n (rst_n),
            .d   (gpio_in[i]),
            .q   (s_in)
         );
         gpio_idx_pin u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_sync   (s_in),
            .wr_en     (wr_hit && (idx == IDX_W'(i))),
            .wcfg      (pin_cfg_t'(bus_wdata[CFG_W-1:0])),
            .wack      (bus_wdata[FLAG_BIT]),
            .rd_word   (rd_words[i]),
            .pad_out   (gpio_out[i]),
            .pad_oe    (gpio_oe[i]),
            .set_pulse (set_vec[i]),
            .clr_pulse (clr_vec[i])
         );
      end else begin : g_hole
         logic in_unused;
         assign in_unused   = gpio_in[i];
         assign rd_words[i] = '0;
         assign gpio_out[i] = 1'b0;
         assign gpio_oe[i]  = 1'b0;
         assign set_vec[i]  = 1'b0;
         assign clr_vec[i]  = 1'b0;
      end
   end

   assign bus_rdata = hit ? rd_words[idx] : '0;

   gpio_idx_pend #(.N(NUM_PINS), .CW(CNT_W)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .count   (irq_count)
   );

   assign irq_o = (irq_count != '0);
endmodule

// File: rtl/gpio_idx_ctrl_chk.sv
module gpio_idx_ctrl_chk
   import gpio_idx_pkg::*;
#(
   parameter int NUM_GROUPS     = 27,
   parameter int PINS_PER_GROUP = 8,
   parameter int HOLE_GROUP     = 7,
   parameter int HOLE_FIRST     = 4,
   parameter int WINDOW_BYTES   = 4096,
   parameter int REG_BASE       = 256,
   localparam int NUM_PINS      = NUM_GROUPS * PINS_PER_GROUP,
   localparam int ADDR_W        = $clog2(WINDOW_BYTES),
   localparam int IDX_W         = ADDR_W - 2,
   localparam int CNT_W         = $clog2(NUM_PINS + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_sel,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [31:0]         bus_wdata,
   input logic [31:0]         bus_rdata,
   input logic [NUM_PINS-1:0] gpio_out,
   input logic [NUM_PINS-1:0] gpio_oe,
   input logic                irq_o,
   input logic [CNT_W-1:0]    irq_count
);
   logic [ADDR_W-1:0] c_off;
   logic [IDX_W-1:0]  c_idx, idx_q;
   logic              c_hit, c_live, live_wr, drive_q;
   logic              chk_unused;

   assign c_off  = bus_addr - ADDR_W'(REG_BASE);
   assign c_idx  = c_off[ADDR_W-1:2];
   assign c_hit  = (bus_addr >= ADDR_W'(REG_BASE)) && (c_off[1:0] == 2'b00)
                   && (int'(c_idx) < NUM_PINS);
   assign c_live = pin_present(int'(c_idx), PINS_PER_GROUP, HOLE_GROUP, HOLE_FIRST);
   assign live_wr = bus_sel && bus_wr && c_hit && c_live;
   assign chk_unused = ^{bus_wdata[31:13], bus_wdata[11:2], bus_wdata[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         drive_q <= 1'b0;
      end else begin
         idx_q   <= c_idx;
         drive_q <= bus_wdata[DIR_BIT];
      end
   end

   // R2
   oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live_wr |=> gpio_oe[idx_q] == drive_q);

   // R2
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr) |=> $stable(gpio_out));

   // R10
   single_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_count < $past(irq_count)) |-> (irq_count == $past(irq_count) - CNT_W'(1)));

   // R10
   irq_fall_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(bus_sel && bus_wr && bus_wdata[FLAG_BIT]));

   // R11
   hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && c_hit && !c_live) |-> bus_rdata == 32'd0);

   // R12
   unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && !c_hit) |-> bus_rdata == 32'd0);
endmodule

bind gpio_idx_ctrl gpio_idx_ctrl_chk #(
   .NUM_GROUPS     (NUM_GROUPS),
   .PINS_PER_GROUP (PINS_PER_GROUP),
   .HOLE_GROUP     (HOLE_GROUP),
   .HOLE_FIRST     (HOLE_FIRST),
   .WINDOW_BYTES   (WINDOW_BYTES),
   .REG_BASE       (REG_BASE)
) chk_i (.*);

// File: tb/gpio_idx_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_idx_ctrl_tb_top;
   localparam int NP   = 216;
   localparam int AW   = 12;
   localparam int CW   = 8;
   localparam int BASE = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] gpio_in = '0;
   logic [NP-1:0] gpio_out, gpio_oe;
   logic          irq_o;
   logic [CW-1:0] irq_count;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_idx_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
      .irq_o(irq_o), .irq_count(irq_count)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_addr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_addr(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   function automatic logic [AW-1:0] pa(input int n);
      return AW'(BASE + 4 * n);
   endfunction

   task automatic set_in(input int n, input logic v);
      @(negedge clk);
      gpio_in[n] = v;
      repeat (3) @(posedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd_addr(pa(0), d);   check("R3 word pin0", d, 0);
      rd_addr(pa(100), d); check("R3 word pin100", d, 0);
      check("R3 oe none", 32'(gpio_oe != '0), 0);
      check("R3 count", 32'(irq_count), 0);
      check("R3 irq", 32'(irq_o), 0);
   endtask

   task automatic t_layout();
      logic [31:0] d;
      wr_addr(pa(5), 32'h0000_003F);
      rd_addr(pa(5), d); check("R1 fields readback", d, 32'h3F);
      check("R2 out pin5", 32'(gpio_out[5]), 1);
      check("R2 oe pin5", 32'(gpio_oe[5]), 1);
      check("R2 no spill pin6", 32'(gpio_oe[6]), 0);
      wr_addr(pa(5), 32'hFFFF_EFC2);
      rd_addr(pa(5), d); check("R1 reserved zero, R4 level read-only", d, 32'h02);
      check("R2 out cleared", 32'(gpio_out[5]), 0);
      check("R2 oe kept", 32'(gpio_oe[5]), 1);
      wr_addr(pa(5), 0);
   endtask

   task automatic t_input();
      logic [31:0] d;
      @(negedge clk);
      gpio_in[10] = 1'b1;
      repeat (2) @(posedge clk);
      rd_addr(pa(10), d); check("R4 not after two edges", d[13], 0);
      rd_addr(pa(10), d); check("R4 after third edge", d[13], 1);
      set_in(10, 1'b0);
      rd_addr(pa(10), d); check("R4 falls back", d[13], 0);
   endtask

   task automatic t_edges();
      logic [31:0] d;
      wr_addr(pa(20), 32'h0C);             // rising, enabled
      set_in(20, 1'b1); @(negedge clk);
      rd_addr(pa(20), d); check("R5 rise sets flag", d[12], 1);
      check("R10 count one", 32'(irq_count), 1);
      check("R10 irq high", 32'(irq_o), 1);
      set_in(20, 1'b0);
      wr_addr(pa(20), 32'h100C);
      rd_addr(pa(20), d); check("R5 flag acked", d[12], 0);
      check("R10 count zero", 32'(irq_count), 0);

      wr_addr(pa(21), 32'h04);             // falling, enabled
      set_in(21, 1'b1); @(negedge clk);
      rd_addr(pa(21), d); check("R5 rise ignored by falling type", d[12], 0);
      set_in(21, 1'b0); @(negedge clk);
      rd_addr(pa(21), d); check("R5 fall sets flag", d[12], 1);
      wr_addr(pa(21), 32'h1004);

      wr_addr(pa(22), 32'h14);             // both edges
      set_in(22, 1'b1); @(negedge clk);
      rd_addr(pa(22), d); check("R5 both: rise", d[12], 1);
      wr_addr(pa(22), 32'h1014);
      set_in(22, 1'b0); @(negedge clk);
      rd_addr(pa(22), d); check("R5 both: fall", d[12], 1);
      wr_addr(pa(22), 32'h1014);
      check("R10 count back to zero", 32'(irq_count), 0);
   endtask

   task automatic t_level();
      logic [31:0] d;
      wr_addr(pa(30), 32'h1C);
      set_in(30, 1'b1); @(negedge clk);
      rd_addr(pa(30), d); check("R6 level sets", d[12], 1);
      wr_addr(pa(30), 32'h101C);
      rd_addr(pa(30), d); check("R6 ack while high keeps flag", d[12], 1);
      check("R6 count unchanged", 32'(irq_count), 1);
      set_in(30, 1'b0);
      wr_addr(pa(30), 32'h101C);
      rd_addr(pa(30), d); check("R6 ack after low clears", d[12], 0);
      check("R6 count zero", 32'(irq_count), 0);
      wr_addr(pa(30), 0);
   endtask

   task automatic t_disabled_masked();
      logic [31:0] d;
      wr_addr(pa(40), 32'h08);             // rising, not enabled
      set_in(40, 1'b1); @(negedge clk);
      rd_addr(pa(40), d); check("R7 no flag when disabled", d[12], 0);
      check("R7 input still tracked", d[13], 1);
      check("R7 count zero", 32'(irq_count), 0);
      wr_addr(pa(41), 32'h2C);             // rising, enabled, gated
      set_in(41, 1'b1); @(negedge clk);
      rd_addr(pa(41), d); check("R8 level held", d[13], 0);
      check("R8 no flag", d[12], 0);
      check("R8 count zero", 32'(irq_count), 0);
      set_in(41, 1'b0); set_in(40, 1'b0);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      wr_addr(pa(0), 32'h0C);
      wr_addr(pa(1), 32'h0C);
      @(negedge clk);
      gpio_in[0] = 1'b1; gpio_in[1] = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R10 simultaneous sets count two", 32'(irq_count), 2);
      wr_addr(pa(1), 32'h0C);              // flag bit written as 0
      rd_addr(pa(1), d); check("R9 zero write keeps flag", d[12], 1);
      check("R9 count still two", 32'(irq_count), 2);
      wr_addr(pa(0), 32'h100C);
      rd_addr(pa(0), d); check("R9 acked pin cleared", d[12], 0);
      rd_addr(pa(1), d); check("R9 neighbour kept", d[12], 1);
      check("R10 count two to one", 32'(irq_count), 1);
      check("R10 irq still high", 32'(irq_o), 1);
      wr_addr(pa(1), 32'h100C);
      check("R10 count zero", 32'(irq_count), 0);
      check("R10 irq low", 32'(irq_o), 0);
      @(negedge clk); gpio_in[0] = 1'b0; gpio_in[1] = 1'b0;
      repeat (3) @(posedge clk);
   endtask

   task automatic t_holes();
      logic [31:0] d;
      wr_addr(pa(61), 32'h3F);
      rd_addr(pa(61), d); check("R11 absent reads zero", d, 0);
      check("R11 absent oe low", 32'(gpio_oe[61]), 0);
      wr_addr(pa(59), 32'h03);
      rd_addr(pa(59), d); check("R11 present neighbour works", d, 32'h03);
      check("R11 present oe", 32'(gpio_oe[59]), 1);
      wr_addr(pa(59), 0);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      wr_addr(12'h0FC, 32'h3F);
      rd_addr(12'h0FC, d); check("R12 below base", d, 0);
      wr_addr(pa(216), 32'h3F);
      rd_addr(pa(216), d); check("R12 past last pin", d, 0);
      wr_addr(12'h102, 32'h3F);
      rd_addr(12'h102, d); check("R12 misaligned", d, 0);
      rd_addr(pa(0), d); check("R12 pin0 untouched", d[5:0], 32'h0C);
      check("R12 no oe", 32'(gpio_oe != '0), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_layout();
      t_input();
      t_edges();
      t_level();
      t_disabled_masked();
      t_w1c();
      t_holes();
      t_unmapped();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule